// File: doc/BRIEF.md
# Parallel Host Register Bus Interface

This block sits on the slave side of a parallel host bus and turns host cycles into register read and write requests toward a peripheral's internal register file. The host drives an 8-bit data bus, a 4-bit register address, an active-low chip select, a direction level and an active-low enable strobe. The direction line is a level, not a strobe. When it is high the cycle is a read, and when it is low the cycle is a write. An access is live only while chip select and the strobe are both low. All host inputs are brought into the system clock domain through a multi-stage synchronizer before they are decoded. The block also produces an active-low interrupt from a set of request and enable lines.

The bus mode is set by a sticky latch that watches a mode pin. While that pin stays at one level, the address comes from the dedicated address pins. The first edge seen on the pin moves the interface into a shared address/data mode, and only a reset clears it. In that mode every falling edge of the pin captures the low nibble of the data bus as the register address for the data phases that follow. A parameter can remove the mode switch so that the dedicated-address mode is fixed.

Top module: `host_bus_if`

## Requirements
- R1: While reset is asserted and immediately after it, `data_oe_o` is 0, `reg_wr_o` is 0, `irq_no` is 1 and `mux_mode_o` is 0.
- R2: An access with `cs_ni`=0, `wr_ni`=0 and `rd_i`=0 produces exactly one `reg_wr_o` pulse, one clock wide, however long the strobe is held. The pulse appears in the cycle after the second rising clock edge that samples the low strobe. During the pulse, `reg_addr_o` carries the host address and `reg_wdata_o` carries the bus data.
- R3: An access with `cs_ni`=0, `wr_ni`=0 and `rd_i`=1 raises `data_oe_o` two clock edges later and presents `reg_addr_o` at the host address. `data_o` then equals `reg_rdata_i`. When the strobe rises, `data_oe_o` drops two edges later.
- R4: While `cs_ni`=1, no `reg_wr_o` pulse occurs and `data_oe_o` stays 0, whatever the other lines do.
- R5: While `wr_ni`=1, no `reg_wr_o` pulse occurs and `data_oe_o` stays 0, even with `cs_ni`=0.
- R6: While `mode_i` holds one level after reset, `mux_mode_o` stays 0 and `reg_addr_o` follows `addr_i`.
- R7: Any rising or falling edge on `mode_i` sets `mux_mode_o` to 1. It stays 1 through any later activity on `mode_i` until reset.
- R8: In shared mode, a falling edge on `mode_i` captures `data_i[3:0]` as the register address. Later accesses use that address on `reg_addr_o`, and `addr_i` is ignored.
- R9: With `MUX_EN`=0, edges on `mode_i` leave `mux_mode_o` at 0, and `reg_addr_o` keeps following `addr_i`.
- R10: One clock edge after any change of the request lines, `irq_no` is 0 when some bit has both `irq_req_i` and `irq_en_i` set, and 1 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| cs_ni | input | 1 | Chip select, active low |
| wr_ni | input | 1 | Access enable strobe, active low |
| rd_i | input | 1 | Direction level: 1 read, 0 write |
| mode_i | input | 1 | Bus mode pin / address latch strobe |
| addr_i | input | 4 | Dedicated register address pins |
| data_i | input | 8 | Data bus, input side |
| data_o | output | 8 | Data bus, output side |
| data_oe_o | output | 1 | Data bus output enable |
| reg_addr_o | output | 4 | Register address toward register file |
| reg_wr_o | output | 1 | One-cycle register write request |
| reg_wdata_o | output | 8 | Register write data |
| reg_rdata_i | input | 8 | Register read data from register file |
| irq_req_i | input | 4 | Interrupt request lines |
| irq_en_i | input | 4 | Interrupt enable per request |
| irq_no | output | 1 | Interrupt output, active low |
| mux_mode_o | output | 1 | Shared address/data mode active |

## Verification
The hardest condition to reach is the shared-mode address path. It only exists after an edge on the mode pin, it cannot be undone without a reset, and it needs the address nibble on the data bus to line up with a falling mode edge. The stimulus first runs every dedicated-address read and write while the mode pin is held steady. It then toggles the pin and, for each of several addresses, places the address on the data bus with a conflicting value on the address pins, lowers the mode pin, swaps in write data and strobes. After that, reset is applied to show that the mode clears. A second instance built with the mode switch removed sees the same toggles, to show that it stays in dedicated mode.

// File: rtl/host_bus_pkg.sv
package host_bus_pkg;
  localparam int unsigned HB_ADDR_W = 4;
  localparam int unsigned HB_DATA_W = 8;

  typedef struct packed {
    logic cs_n;
    logic wr_n;
    logic rd;
    logic mode;
  } hb_ctrl_t;

  localparam int unsigned HB_CTRL_W = $bits(hb_ctrl_t);
  localparam hb_ctrl_t HB_CTRL_IDLE = '{cs_n: 1'b1, wr_n: 1'b1, rd: 1'b0, mode: 1'b0};
endpackage

// File: rtl/hbi_sync.sv
module hbi_sync #(
  parameter int unsigned W       = 1,
  parameter int unsigned STAGES  = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    logic [W-1:0] src;
    if (s == 0) begin : g_first
      assign src = d_i;
    end else begin : g_next
      assign src = stage_q[s-1];
    end
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stage_q[s] <= RST_VAL;
      else         stage_q[s] <= src;
    end
  end

  assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/hbi_mode_latch.sv
module hbi_mode_latch #(
  parameter bit          MUX_EN = 1'b1,
  parameter int unsigned STAGES = 2,
  parameter int unsigned AW     = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          mode_s_i,
  input  logic [AW-1:0] bus_lo_i,
  output logic          mux_o,
  output logic [AW-1:0] lat_addr_o
);
  // arm after the synchronizer has flushed its reset value
  logic [STAGES:0] arm_q;
  logic            mode_q;
  logic            primed;
  logic            edge_seen;
  logic            fall_seen;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      arm_q  <= '0;
      mode_q <= 1'b0;
    end else begin
      arm_q  <= {arm_q[STAGES-1:0], 1'b1};
      mode_q <= mode_s_i;
    end
  end

  assign primed    = arm_q[STAGES];
  assign edge_seen = primed && (mode_s_i != mode_q);
  assign fall_seen = edge_seen && mode_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        lat_addr_o <= '0;
    else if (fall_seen) lat_addr_o <= bus_lo_i;
  end

  if (MUX_EN) begin : g_mux
    logic mux_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)        mux_q <= 1'b0;
      else if (edge_seen) mux_q <= 1'b1;
    end
    assign mux_o = mux_q;

    assert_mux_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      mux_o |=> mux_o);
    assert_edge_sets_mux_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      edge_seen |=> mux_o);
  end else begin : g_fixed
    assign mux_o = 1'b0;
  end
endmodule

// File: rtl/hbi_access.sv
module hbi_access #(
  parameter int unsigned AW = 4,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          cs_n_i,
  input  logic          wr_n_i,
  input  logic          rd_i,
  input  logic          mux_i,
  input  logic [AW-1:0] pin_addr_i,
  input  logic [AW-1:0] lat_addr_i,
  input  logic [DW-1:0] bus_data_i,
  input  logic [DW-1:0] rdata_i,
  output logic [AW-1:0] reg_addr_o,
  output logic          reg_wr_o,
  output logic [DW-1:0] reg_wdata_o,
  output logic [DW-1:0] data_o,
  output logic          data_oe_o
);
  logic active;
  logic act_q;

  assign active = !cs_n_i && !wr_n_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) act_q <= 1'b0;
    else         act_q <= active;
  end

  assign reg_addr_o  = mux_i ? lat_addr_i : pin_addr_i;
  assign reg_wr_o    = active && !act_q && !rd_i;
  assign reg_wdata_o = bus_data_i;
  assign data_oe_o   = active && rd_i;
  assign data_o      = data_oe_o ? rdata_i : '0;

  assert_single_write_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_wr_o |=> !reg_wr_o);
  assert_no_write_on_read_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> !reg_wr_o);
  assert_cs_gates_access_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_n_i |-> !(reg_wr_o || data_oe_o));
  assert_strobe_gates_access_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_n_i |-> !(reg_wr_o || data_oe_o));
endmodule

// File: rtl/hbi_irq.sv
module hbi_irq #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] req_i,
  input  logic [N-1:0] en_i,
  output logic         irq_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_no <= 1'b1;
    else         irq_no <= ~|(req_i & en_i);
  end

  assert_irq_low_when_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(req_i & en_i)) |=> !irq_no);
  assert_irq_high_when_idle_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(|(req_i & en_i)) |=> irq_no);
endmodule

// File: rtl/host_bus_if.sv
module host_bus_if
  import host_bus_pkg::*;
#(
  parameter bit          MUX_EN      = 1'b1,
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned N_IRQ       = 4
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 wr_ni,
  input  logic                 rd_i,
  input  logic                 mode_i,
  input  logic [HB_ADDR_W-1:0] addr_i,
  input  logic [HB_DATA_W-1:0] data_i,
  output logic [HB_DATA_W-1:0] data_o,
  output logic                 data_oe_o,
  output logic [HB_ADDR_W-1:0] reg_addr_o,
  output logic                 reg_wr_o,
  output logic [HB_DATA_W-1:0] reg_wdata_o,
  input  logic [HB_DATA_W-1:0] reg_rdata_i,
  input  logic [N_IRQ-1:0]     irq_req_i,
  input  logic [N_IRQ-1:0]     irq_en_i,
  output logic                 irq_no,
  output logic                 mux_mode_o
);
  localparam int unsigned BUS_W = HB_ADDR_W + HB_DATA_W;

  hb_ctrl_t             ctrl_raw, ctrl_s;
  logic [HB_CTRL_W-1:0] ctrl_s_bits;
  logic [BUS_W-1:0]     bus_s;
  logic [HB_ADDR_W-1:0] addr_s, lat_addr;
  logic [HB_DATA_W-1:0] data_s;

  assign ctrl_raw = '{cs_n: cs_ni, wr_n: wr_ni, rd: rd_i, mode: mode_i};

  hbi_sync #(.W(HB_CTRL_W), .STAGES(SYNC_STAGES), .RST_VAL(HB_CTRL_IDLE)) u_sync_ctrl (
    .clk_i, .rst_ni, .d_i(ctrl_raw), .q_o(ctrl_s_bits)
  );
  assign ctrl_s = hb_ctrl_t'(ctrl_s_bits);

  hbi_sync #(.W(BUS_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_sync_bus (
    .clk_i, .rst_ni, .d_i({addr_i, data_i}), .q_o(bus_s)
  );
  assign {addr_s, data_s} = bus_s;

  hbi_mode_latch #(.MUX_EN(MUX_EN), .STAGES(SYNC_STAGES), .AW(HB_ADDR_W)) u_mode (
    .clk_i, .rst_ni,
    .mode_s_i  (ctrl_s.mode),
    .bus_lo_i  (data_s[HB_ADDR_W-1:0]),
    .mux_o     (mux_mode_o),
    .lat_addr_o(lat_addr)
  );

  hbi_access #(.AW(HB_ADDR_W), .DW(HB_DATA_W)) u_access (
    .clk_i, .rst_ni,
    .cs_n_i     (ctrl_s.cs_n),
    .wr_n_i     (ctrl_s.wr_n),
    .rd_i       (ctrl_s.rd),
    .mux_i      (mux_mode_o),
    .pin_addr_i (addr_s),
    .lat_addr_i (lat_addr),
    .bus_data_i (data_s),
    .rdata_i    (reg_rdata_i),
    .reg_addr_o (reg_addr_o),
    .reg_wr_o   (reg_wr_o),
    .reg_wdata_o(reg_wdata_o),
    .data_o     (data_o),
    .data_oe_o  (data_oe_o)
  );

  hbi_irq #(.N(N_IRQ)) u_irq (
    .clk_i, .rst_ni, .req_i(irq_req_i), .en_i(irq_en_i), .irq_no(irq_no)
  );

  assert_dedicated_addr_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !mux_mode_o |-> reg_addr_o == addr_s);
endmodule

// File: tb/host_bus_if_tb_top.sv
module host_bus_if_tb_top;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n = 1'b0;
  logic       cs_n = 1'b1, wr_n = 1'b1, rd = 1'b0, mode = 1'b0;
  logic [3:0] addr = '0;
  logic [7:0] data = '0;
  logic [3:0] req = '0, en = '0;

  logic [7:0] data_o, wdata, rdata;
  logic       oe, wr_p, irq_n, mux;
  logic [3:0] raddr;
  logic [7:0] data_o_b, wdata_b;
  logic       oe_b, wr_b, irq_b, mux_b;
  logic [3:0] raddr_b;

  assign rdata = {~raddr, raddr};

  host_bus_if dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .rd_i(rd), .mode_i(mode),
    .addr_i(addr), .data_i(data), .data_o(data_o), .data_oe_o(oe), .reg_addr_o(raddr),
    .reg_wr_o(wr_p), .reg_wdata_o(wdata), .reg_rdata_i(rdata), .irq_req_i(req),
    .irq_en_i(en), .irq_no(irq_n), .mux_mode_o(mux)
  );

  host_bus_if #(.MUX_EN(1'b0)) dut_nomux_i (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .wr_ni(wr_n), .rd_i(rd), .mode_i(mode),
    .addr_i(addr), .data_i(data), .data_o(data_o_b), .data_oe_o(oe_b), .reg_addr_o(raddr_b),
    .reg_wr_o(wr_b), .reg_wdata_o(wdata_b), .reg_rdata_i(8'h00), .irq_req_i(req),
    .irq_en_i(en), .irq_no(irq_b), .mux_mode_o(mux_b)
  );

  int checks = 0;
  int errors = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check_reset_state(input string tag);
    check(oe == 1'b0,    {tag, " R1 oe"},  oe,    0);
    check(wr_p == 1'b0,  {tag, " R1 wr"},  wr_p,  0);
    check(irq_n == 1'b1, {tag, " R1 irq"}, irq_n, 1);
    check(mux == 1'b0,   {tag, " R1 mux"}, mux,   0);
  endtask

  task automatic do_write(input logic [3:0] a, input logic [7:0] d, input logic [3:0] exp_a);
    addr = a; data = d; rd = 1'b0;
    tick(2);
    cs_n = 1'b0; wr_n = 1'b0;
    tick(1);
    check(wr_p == 1'b0, "R2 no early pulse", wr_p, 0);
    tick(1);
    check(wr_p == 1'b1, "R2 pulse", wr_p, 1);
    check(raddr == exp_a, "R2 addr", raddr, exp_a);
    check(wdata == d, "R2 wdata", wdata, d);
    tick(1);
    check(wr_p == 1'b0, "R2 one cycle", wr_p, 0);
    tick(3);
    check(wr_p == 1'b0, "R2 held strobe", wr_p, 0);
    cs_n = 1'b1; wr_n = 1'b1;
    tick(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    tick(2);
    check_reset_state("in reset");
    rst_n = 1'b1;
    tick(6);
    check_reset_state("after reset");

    // R2: write sweep over all addresses
    for (int a = 0; a < 16; a++) begin
      do_write(4'(a), 8'((a * 37) ^ 8'h5a), 4'(a));
    end

    // R3: read sweep
    for (int a = 0; a < 16; a++) begin
      addr = 4'(a); rd = 1'b1; data = 8'hff;
      tick(2);
      cs_n = 1'b0; wr_n = 1'b0;
      tick(1);
      check(oe == 1'b0, "R3 oe latency", oe, 0);
      tick(1);
      check(oe == 1'b1, "R3 oe", oe, 1);
      check(raddr == 4'(a), "R3 addr", raddr, a);
      check(data_o == {~4'(a), 4'(a)}, "R3 data", data_o, {~4'(a), 4'(a)});
      check(wr_p == 1'b0, "R3 no write", wr_p, 0);
      wr_n = 1'b1;
      tick(1);
      check(oe == 1'b1, "R3 release latency", oe, 1);
      tick(1);
      check(oe == 1'b0, "R3 release", oe, 0);
      cs_n = 1'b1;
      tick(2);
    end

    // R4: chip select high blocks everything
    for (int r = 0; r < 2; r++) begin
      rd = r[0]; cs_n = 1'b1; wr_n = 1'b0;
      for (int k = 0; k < 5; k++) begin
        tick(1);
        check(!wr_p && !oe, "R4 cs high", {wr_p, oe}, 0);
      end
      wr_n = 1'b1;
      tick(2);
    end

    // R5: strobe high blocks everything
    for (int r = 0; r < 2; r++) begin
      rd = r[0]; cs_n = 1'b0; wr_n = 1'b1;
      for (int k = 0; k < 5; k++) begin
        tick(1);
        check(!wr_p && !oe, "R5 strobe high", {wr_p, oe}, 0);
      end
      cs_n = 1'b1;
      tick(2);
    end

    // R10: every request/enable combination
    for (int r = 0; r < 16; r++) begin
      for (int e = 0; e < 16; e++) begin
        req = 4'(r); en = 4'(e);
        tick(1);
        check(irq_n == ((r & e) == 0), "R10 irq", irq_n, (r & e) == 0);
      end
    end
    req = '0; en = '0;

    // R6: steady mode pin keeps dedicated mode
    addr = 4'h9;
    tick(3);
    check(mux == 1'b0, "R6 mux", mux, 0);
    check(raddr == 4'h9, "R6 addr", raddr, 9);

    // R7: first edge enters shared mode
    data = 8'h00; mode = 1'b1;
    tick(4);
    check(mux == 1'b1, "R7 rising edge", mux, 1);
    check(mux_b == 1'b0, "R9 no mux", mux_b, 0);

    // R8: latched address from data bus
    for (int a = 1; a < 16; a += 3) begin
      addr = ~4'(a); data = {4'h0, 4'(a)};
      tick(3);
      mode = 1'b0;
      tick(4);
      data = 8'(8'hc3 ^ a);
      do_write(~4'(a), 8'(8'hc3 ^ a), 4'(a));
      check(raddr_b == ~4'(a), "R9 pin addr", raddr_b, ~4'(a));
      check(mux == 1'b1, "R7 sticky", mux, 1);
      check(mux_b == 1'b0, "R9 stays fixed", mux_b, 0);
      mode = 1'b1;
      tick(4);
    end

    // R7 cleared by reset
    rst_n = 1'b0;
    tick(1);
    check_reset_state("reset again");
    rst_n = 1'b1;
    tick(6);
    check(mux == 1'b0, "R7 stays clear after reset", mux, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule